// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block decides when an in-order processor core stops and enters debug mode. It sees the pipeline only through a few per-cycle flags: an instruction was latched, an instruction was executed, an instruction was aborted, and the executed instruction was a breakpoint opcode. It also sees a low-power indication, a software strobe that sets the debug request bit, a force-debug enable, a trace enable, and a write port for a trace counter.

Debug entry never happens at once. A cause (a request, a breakpoint with force-debug enabled, or the trace counter running out) arms the controller. The halt then lands when the next instruction enters the instruction latch. If the core is asleep when a request arrives, the block first asks it to wake. A one-cycle release strobe ends debug mode and clears every recorded cause.

A single state machine drives the outputs. Its states are RUN, WAKE, ARMED and HALTED. The transitions are:

- RUN→ARMED: a new cause arrives while the core is awake.
- RUN→WAKE: a new cause arrives while the core is in a low-power state.
- WAKE→ARMED: the low-power state ends.
- ARMED→HALTED: an instruction is latched.
- HALTED→RUN: the release strobe is seen.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: After reset, `debug_mode`, `wake_req`, `core_halt`, `cause_status` and `trace_count` are all zero.
- R2: A `dreq_set` pulse while awake and running arms the controller. `core_halt` goes high in the first later cycle that has `instr_latched`. `debug_mode` goes high one cycle after that. Cycles without `instr_latched` keep the core running.
- R3: A `dreq_set` pulse while `low_power` is high raises `wake_req` from the next cycle until `low_power` falls. After that, entry waits for a latched instruction as in R2.
- R4: An executed, non-aborted instruction with `instr_bkpt` high while `force_dbg` is set arms debug entry. The halt comes on the next latched instruction.
- R5: A breakpoint executed while `force_dbg` is clear is ignored: no entry follows and `cause_status` stays unchanged.
- R6: While `trace_en` is set and `trace_count` is above zero, each executed, non-aborted instruction lowers the count by one.
- R7: An executed, non-aborted instruction while `trace_en` is set and `trace_count` is zero arms debug entry. The count stays at zero.
- R8: An instruction with `instr_aborted` high is treated as not executed, even if `instr_executed` is also high. It neither lowers the count nor triggers entry.
- R9: Causes that arrive together, or while entry is pending, merge into one entry. `cause_status` ORs them together: bit 0 is the request, bit 1 the breakpoint, bit 2 the trace.
- R10: `release_dbg` while halted returns to RUN the next cycle and clears `cause_status`. `release_dbg` in any other state has no effect.
- R11: `trace_wr` loads `trace_wdata` into the counter at the next edge, in any state. A load wins over a decrement in the same cycle.
- R12: While halted, new causes are not recorded and the counter does not decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_latched | input | 1 | A fetched instruction entered the instruction latch |
| instr_executed | input | 1 | An instruction completed execution |
| instr_aborted | input | 1 | The completing instruction was aborted |
| instr_bkpt | input | 1 | The completing instruction is a breakpoint opcode |
| low_power | input | 1 | Core is in stop, doze or wait |
| dreq_set | input | 1 | Software write setting the debug request bit |
| force_dbg | input | 1 | Breakpoints force debug entry |
| trace_en | input | 1 | Trace counting enabled |
| trace_wr | input | 1 | Load strobe for the trace counter |
| trace_wdata | input | TRACE_W | Trace counter load value |
| release_dbg | input | 1 | One-cycle strobe leaving debug mode |
| debug_mode | output | 1 | Core is in debug mode |
| wake_req | output | 1 | Request to leave the low-power state |
| core_halt | output | 1 | Halt the core pipeline |
| cause_status | output | 3 | Causes recorded for the pending or current entry |
| trace_count | output | TRACE_W | Current trace counter value |

## Verification
The hardest case to reach is several causes overlapping in flight. Examples are a request landing while the core sleeps, a trace expiry while entry is already armed, and an aborted instruction arriving in the same cycle as a zero count. Directed scenes build these overlaps one at a time. A long stretch follows with all pipeline flags, low-power periods, counter loads and releases drawn at random. Throughout, a behavioural reference model in the bench predicts every output on every cycle.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_WAKE   = 2'd1,
        ST_ARMED  = 2'd2,
        ST_HALTED = 2'd3
    } dbg_state_e;

    localparam int CAUSE_N     = 3;
    localparam int CAUSE_REQ   = 0;
    localparam int CAUSE_BKPT  = 1;
    localparam int CAUSE_TRACE = 2;
endpackage

// File: rtl/dbg_trace_counter.sv
module dbg_trace_counter #(
    parameter int TRACE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [TRACE_W-1:0] wdata,
    input  logic               en,
    input  logic               exec_ok,
    input  logic               halted,
    output logic [TRACE_W-1:0] count,
    output logic               hit
);
    localparam logic [TRACE_W-1:0] ZERO = '0;

    logic at_zero;
    assign at_zero = (count == ZERO);
    assign hit     = en && exec_ok && at_zero && !halted;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= ZERO;
        end else if (wr) begin
            count <= wdata;
        end else if (en && exec_ok && !at_zero && !halted) begin
            count <= count - 1'b1;
        end
    end

    // R8: no executed instruction, no change to the count
    p_abort_no_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !exec_ok) |=> $stable(count));
    // R7: the count holds at zero
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && at_zero) |=> (count == ZERO));
    // R11: a load wins over a decrement
    p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (count == $past(wdata)));
endmodule

// File: rtl/dbg_cause_collect.sv
module dbg_cause_collect
    import dbg_entry_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_set,
    input  logic               bkpt_hit,
    input  logic               trace_hit,
    input  logic               halted,
    input  logic               release_ok,
    output logic [CAUSE_N-1:0] status,
    output logic               new_cause
);
    logic [CAUSE_N-1:0] incoming;

    always_comb begin
        incoming              = '0;
        incoming[CAUSE_REQ]   = req_set;
        incoming[CAUSE_BKPT]  = bkpt_hit;
        incoming[CAUSE_TRACE] = trace_hit;
        if (halted) incoming = '0;
    end

    assign new_cause = |incoming;

    always_ff @(posedge clk) begin
        if (!rst_n || release_ok) begin
            status <= '0;
        end else begin
            status <= status | incoming;
        end
    end

    // R10: a release clears every recorded cause
    p_clear_on_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        release_ok |=> (status == '0));
    // R12: nothing is recorded while halted
    p_frozen_halted_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !release_ok) |=> $stable(status));
endmodule

// File: rtl/dbg_entry_fsm.sv
module dbg_entry_fsm
    import dbg_entry_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       new_cause,
    input  logic       low_power,
    input  logic       latched,
    input  logic       release_dbg,
    output dbg_state_e state,
    output logic       debug_mode,
    output logic       wake_req,
    output logic       core_halt
);
    dbg_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:    if (new_cause) state_nx = low_power ? ST_WAKE : ST_ARMED;
            ST_WAKE:   if (!low_power) state_nx = ST_ARMED;
            ST_ARMED:  if (latched) state_nx = ST_HALTED;
            ST_HALTED: if (release_dbg) state_nx = ST_RUN;
            default:   state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        debug_mode = 1'b0;
        wake_req   = 1'b0;
        core_halt  = 1'b0;
        unique case (state)
            ST_RUN:    ;
            ST_WAKE:   wake_req = 1'b1;
            ST_ARMED:  core_halt = latched;
            ST_HALTED: begin
                debug_mode = 1'b1;
                core_halt  = 1'b1;
            end
            default:   ;
        endcase
    end

    // R2: halting needs a latched instruction
    p_halt_after_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && !latched) |=> (state != ST_HALTED));
    // R3: a cause while asleep asks for wake-up
    p_wake_lowpower_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && new_cause && low_power) |=> wake_req);
    // R10: release leaves debug mode
    p_release_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALTED && release_dbg) |=> !debug_mode);
    // R10: release outside debug mode is ignored
    p_release_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !new_cause) |=> (state == ST_RUN));
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
    import dbg_entry_pkg::*;
#(
    parameter int TRACE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_latched,
    input  logic               instr_executed,
    input  logic               instr_aborted,
    input  logic               instr_bkpt,
    input  logic               low_power,
    input  logic               dreq_set,
    input  logic               force_dbg,
    input  logic               trace_en,
    input  logic               trace_wr,
    input  logic [TRACE_W-1:0] trace_wdata,
    input  logic               release_dbg,
    output logic               debug_mode,
    output logic               wake_req,
    output logic               core_halt,
    output logic [CAUSE_N-1:0] cause_status,
    output logic [TRACE_W-1:0] trace_count
);
    dbg_state_e state;
    logic       exec_ok, halted, trace_hit, bkpt_hit, new_cause;

    assign exec_ok  = instr_executed && !instr_aborted;
    assign halted   = (state == ST_HALTED);
    assign bkpt_hit = exec_ok && instr_bkpt && force_dbg;

    dbg_trace_counter #(.TRACE_W(TRACE_W)) u_trace (
        .clk(clk), .rst_n(rst_n), .wr(trace_wr), .wdata(trace_wdata),
        .en(trace_en), .exec_ok(exec_ok), .halted(halted),
        .count(trace_count), .hit(trace_hit)
    );

    dbg_cause_collect u_cause (
        .clk(clk), .rst_n(rst_n), .req_set(dreq_set), .bkpt_hit(bkpt_hit),
        .trace_hit(trace_hit), .halted(halted),
        .release_ok(halted && release_dbg),
        .status(cause_status), .new_cause(new_cause)
    );

    dbg_entry_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .new_cause(new_cause), .low_power(low_power),
        .latched(instr_latched), .release_dbg(release_dbg), .state(state),
        .debug_mode(debug_mode), .wake_req(wake_req), .core_halt(core_halt)
    );

    // R5: a breakpoint without force-debug arms nothing
    p_bkpt_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && exec_ok && instr_bkpt && !force_dbg && !dreq_set && !trace_hit)
        |=> (state == ST_RUN));
endmodule

// File: tb/dbg_entry_ctrl_bench.sv
module dbg_entry_ctrl_bench;
    localparam int TW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lat = 0, exe = 0, abt = 0, bkp = 0, lp = 0, dreq = 0, frc = 0, ten = 0, twr = 0, rel = 0;
    logic [TW-1:0] twd = '0;
    logic dbg_o, wake_o, halt_o;
    logic [2:0] st_o;
    logic [TW-1:0] cnt_o;

    int checks = 0, errors = 0;
    string cur_req = "R1";

    // model state: 0 run, 1 wake, 2 armed, 3 halted
    int m_st = 0;
    logic [2:0] m_stat = '0;
    int m_cnt = 0;

    always #4 clk = ~clk;

    dbg_entry_ctrl #(.TRACE_W(TW)) u_dbg_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .instr_latched(lat), .instr_executed(exe),
        .instr_aborted(abt), .instr_bkpt(bkp), .low_power(lp), .dreq_set(dreq),
        .force_dbg(frc), .trace_en(ten), .trace_wr(twr), .trace_wdata(twd),
        .release_dbg(rel), .debug_mode(dbg_o), .wake_req(wake_o),
        .core_halt(halt_o), .cause_status(st_o), .trace_count(cnt_o)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_stat = '0; m_cnt = 0;
        end else begin
            bit ok, hit, bk, any;
            int nst;
            ok  = exe && !abt;
            hit = ten && ok && (m_cnt == 0) && (m_st != 3);
            bk  = ok && bkp && frc && (m_st != 3);
            any = (dreq && m_st != 3) || hit || bk;
            nst = m_st;
            case (m_st)
                0: if (any) nst = lp ? 1 : 2;
                1: if (!lp) nst = 2;
                2: if (lat) nst = 3;
                3: if (rel) nst = 0;
                default: nst = 0;
            endcase
            if (m_st == 3 && rel) m_stat = '0;
            else if (m_st != 3) m_stat = m_stat | {hit, bk, dreq};
            if (twr) m_cnt = twd;
            else if (ten && ok && m_cnt > 0 && m_st != 3) m_cnt = m_cnt - 1;
            m_st = nst;
        end
    end

    task automatic cmp(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            cmp("debug_mode R2", dbg_o, m_st == 3);
            cmp("wake_req R3", wake_o, m_st == 1);
            cmp("core_halt R2", halt_o, (m_st == 3) || (m_st == 2 && lat));
            cmp("cause_status R9", st_o, m_stat);
            cmp("trace_count R6", cnt_o, m_cnt);
        end
    end

    task automatic idle();
        lat = 0; exe = 0; abt = 0; bkp = 0; dreq = 0; twr = 0; rel = 0;
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            idle();
        end
    endtask

    task automatic go(); @(negedge clk); endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 200000) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        cur_req = "R1";
        cmp("reset debug_mode R1", dbg_o, 0);
        cmp("reset status R1", st_o, 0);
        cmp("reset count R1", cnt_o, 0);
        // R2: request while running, halt on later latch
        cur_req = "R2";
        go(); dreq = 1; tick(3);
        go(); idle(); lat = 1; tick(2);
        // R10: release, then release in run ignored
        cur_req = "R10";
        go(); rel = 1; tick(2);
        go(); rel = 1; tick(2);
        // R3: request while asleep
        cur_req = "R3";
        lp = 1; go(); dreq = 1; tick(4);
        lp = 0; tick(2); go(); lat = 1; tick(1);
        go(); rel = 1; tick(1);
        // R5: breakpoint without force
        cur_req = "R5";
        frc = 0; go(); exe = 1; bkp = 1; tick(3);
        go(); lat = 1; tick(2);
        // R4: breakpoint with force
        cur_req = "R4";
        frc = 1; go(); exe = 1; bkp = 1; tick(1);
        go(); lat = 1; tick(2);
        go(); rel = 1; tick(1);
        frc = 0;
        // R11, R6, R8, R7: trace
        cur_req = "R11";
        go(); twr = 1; twd = 8'd3; tick(1);
        cur_req = "R6";
        ten = 1; go(); exe = 1; tick(1);
        cur_req = "R8";
        go(); exe = 1; abt = 1; tick(1);
        go(); abt = 1; tick(1);
        cur_req = "R11";
        go(); exe = 1; twr = 1; twd = 8'd2; tick(1);
        cur_req = "R6";
        go(); exe = 1; tick(1); go(); exe = 1; tick(1);
        cur_req = "R8";
        go(); exe = 1; abt = 1; tick(2);
        cur_req = "R7";
        go(); exe = 1; tick(1);
        // R9: merge while armed
        cur_req = "R9";
        go(); dreq = 1; tick(1);
        go(); lat = 1; tick(1);
        // R12: causes while halted are dropped
        cur_req = "R12";
        go(); exe = 1; dreq = 1; tick(2);
        go(); rel = 1; tick(1);
        ten = 0;
        // R9: simultaneous request and breakpoint
        cur_req = "R9";
        frc = 1; go(); dreq = 1; exe = 1; bkp = 1; tick(1);
        go(); lat = 1; tick(1); go(); rel = 1; tick(1);
        // random mix
        cur_req = "R9";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            lat  = ($urandom % 4) == 0;
            exe  = ($urandom % 3) == 0;
            abt  = ($urandom % 5) == 0;
            bkp  = ($urandom % 6) == 0;
            dreq = ($urandom % 40) == 0;
            twr  = ($urandom % 50) == 0;
            twd  = TW'($urandom % 12);
            rel  = ($urandom % 6) == 0;
            if ((i % 97) == 0) lp = ~lp;
            if ((i % 300) == 0) begin frc = $urandom; ten = $urandom; end
        end
        tick(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule